// File: doc/BRIEF.md
# Memory-Mapped 64-Line Interrupt Controller

This block gathers 64 interrupt lines from peripherals and presents them to one CPU over a zero-wait-state APB slave port. Every line passes through a two-stage synchronizer. A line is treated as a level source or as a pulse source according to a build-time mask. For a pulse source, a rising edge sets a sticky flag, and that flag stays set until software clears it with an explicit write. Each source has an enable bit. The enabled sources make up two 32-bit pending words. The CPU request is raised when any pending bit is set and the global enable in the control word is on.

Beside the request line, the block drives the index of the highest-numbered pending source. A handler that always services the most significant pending bit first can therefore take the index without scanning. The block also holds a 64-slot, byte-per-slot table that maps each source to a channel. Software fills the table and the controller only stores it. The usual programming writes the slot index into every byte of a word and ORs in 0x00010203.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `irq_id_o` is 0.
- R2: Bit 31 of the control word at offset 0x00 is the global enable. Only that bit is stored and the other bits read 0. While the bit is 0, `irq_o` is 0 and `irq_id_o` is 0, but the pending words still show the pending sources.
- R3: The enable words are read/write at 0x10 (sources 31..0) and 0x28 (sources 63..32). The pending words are at 0x14 and 0x2C, and each pending bit equals source-active AND enable-bit. The pending words are read-only, and writing them changes nothing.
- R4: For a level source (its `PULSE_MASK` bit is 0), the source is active while its synchronized input is 1. A change on `src_i` driven between two clock edges reaches `irq_o` after the second rising edge that follows.
- R5: For a pulse source (its `PULSE_MASK` bit is 1), a rising edge of the synchronized input sets a flag. The flag reads as 1 at 0x08 (sources 31..0) or at 0x20 (sources 63..32), and it stays 1 after the input returns low. The source is active while its flag is 1.
- R6: A write to a flag word clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1, so a write can never set a flag. An input held high does not set the flag again after it has been cleared.
- R7: The channel table is 16 read/write words at 0x40 + 4*n for n = 0..15, each word holding four byte slots, and all words reset to 0.
- R8: While `irq_o` is 1, `irq_id_o` gives the number (0..63) of the highest-numbered pending source.
- R9: Reads of unmapped offsets (for example 0x04 or 0x80) return 0, and writes to them change no register. `pready_o` is always 1. A write takes effect only in the access phase (`psel_i` and `penable_i` both 1).
- R10: The flag bits of level sources always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| src_i | input | 64 | Interrupt source lines |
| irq_o | output | 1 | CPU interrupt request |
| irq_id_o | output | 6 | Highest pending source number |

## Verification
The bench builds the block with `PULSE_MASK = 64'hFFFF0000_FFFF0000` and the default two synchronizer stages. This gives both the low and the high word a mix of level sources (0..15 and 32..47) and pulse sources (16..31 and 48..63). With that mix, one run can check the level latency, the sticky pulse flags, flag clearing in both words and the zero reading of level-source flags. It can also check the ordering by highest index when a level source and pulse sources in both words are pending at the same time.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned SRC_NUM     = 64;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned SLOTS_WORD  = WORD_W / 8;
    localparam int unsigned TBL_WORDS   = SRC_NUM / SLOTS_WORD;
    localparam int unsigned TBL_IDX_W   = $clog2(TBL_WORDS);
    localparam int unsigned SRC_IDX_W   = $clog2(SRC_NUM);

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_FLAG_LO = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_EN_LO   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_FLAG_HI = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_EN_HI   = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_PEND_HI = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_TABLE   = 12'h040;
    localparam int unsigned       GEN_BIT     = 31;
endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
    parameter int unsigned W          = 64,
    parameter int unsigned STAGES     = 2,
    parameter logic [W-1:0] PULSE_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = src_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev & PULSE_MASK;
endmodule

// File: rtl/intc_chan_table.sv
module intc_chan_table
    import intc_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [TBL_IDX_W-1:0] wr_idx_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic [TBL_IDX_W-1:0] rd_idx_i,
    output logic [WORD_W-1:0]    rdata_o
);
    typedef logic [TBL_WORDS-1:0][WORD_W-1:0] tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) tbl_d[wr_idx_i] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q <= '0;
        else         tbl_q <= tbl_d;
    end

    assign rdata_o = tbl_q[rd_idx_i];

    for (genvar w = 0; w < int'(TBL_WORDS); w++) begin : g_chk
        AST_TBL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && wr_idx_i == TBL_IDX_W'(w)) |=> (rdata_o == $past(wdata_i) || rd_idx_i != TBL_IDX_W'(w))); // R7
    end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int unsigned W     = 64,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |pend_i;

    always_comb begin
        if (any_o) begin
            AST_ID_IS_TOP: assert ((pend_i >> idx_o) == W'(1)); // R8
        end
    end
endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned          SYNC_STAGES = 2,
    parameter logic [SRC_NUM-1:0]   PULSE_MASK  = '0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 psel_i,
    input  logic                 penable_i,
    input  logic                 pwrite_i,
    input  logic [ADDR_W-1:0]    paddr_i,
    input  logic [WORD_W-1:0]    pwdata_i,
    output logic [WORD_W-1:0]    prdata_o,
    output logic                 pready_o,
    input  logic [SRC_NUM-1:0]   src_i,
    output logic                 irq_o,
    output logic [SRC_IDX_W-1:0] irq_id_o
);
    typedef struct packed {
        logic               gen_en;
        logic [SRC_NUM-1:0] en;
        logic [SRC_NUM-1:0] flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [SRC_NUM-1:0]   level, rise, active, pend;
    logic                 wr, tbl_hit, any_pend;
    logic [WORD_W-1:0]    tbl_rdata;
    logic [SRC_IDX_W-1:0] top_idx;

    intc_sync_edge #(
        .W(SRC_NUM), .STAGES(SYNC_STAGES), .PULSE_MASK(PULSE_MASK)
    ) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
        .level_o(level), .rise_o(rise)
    );

    assign wr      = psel_i && penable_i && pwrite_i;
    assign tbl_hit = (paddr_i[ADDR_W-1:6] == OFF_TABLE[ADDR_W-1:6]) && (paddr_i[1:0] == 2'b00);

    intc_chan_table u_tbl (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr && tbl_hit), .wr_idx_i(paddr_i[5:2]), .wdata_i(pwdata_i),
        .rd_idx_i(paddr_i[5:2]), .rdata_o(tbl_rdata)
    );

    assign active = (PULSE_MASK & r_q.flag) | (~PULSE_MASK & level);
    assign pend   = active & r_q.en;

    intc_prio_enc #(.W(SRC_NUM), .IDX_W(SRC_IDX_W)) u_prio (
        .pend_i(pend), .any_o(any_pend), .idx_o(top_idx)
    );

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (paddr_i)
                OFF_CTRL:    r_d.gen_en            = pwdata_i[GEN_BIT];
                OFF_EN_LO:   r_d.en[WORD_W-1:0]    = pwdata_i;
                OFF_EN_HI:   r_d.en[SRC_NUM-1:WORD_W] = pwdata_i;
                OFF_FLAG_LO: r_d.flag[WORD_W-1:0]  = r_q.flag[WORD_W-1:0] & pwdata_i;
                OFF_FLAG_HI: r_d.flag[SRC_NUM-1:WORD_W] = r_q.flag[SRC_NUM-1:WORD_W] & pwdata_i;
                default: ;
            endcase
        end
        r_d.flag = (r_d.flag | rise) & PULSE_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        prdata_o = '0;
        if (tbl_hit) begin
            prdata_o = tbl_rdata;
        end else begin
            case (paddr_i)
                OFF_CTRL:    prdata_o[GEN_BIT] = r_q.gen_en;
                OFF_EN_LO:   prdata_o = r_q.en[WORD_W-1:0];
                OFF_EN_HI:   prdata_o = r_q.en[SRC_NUM-1:WORD_W];
                OFF_PEND_LO: prdata_o = pend[WORD_W-1:0];
                OFF_PEND_HI: prdata_o = pend[SRC_NUM-1:WORD_W];
                OFF_FLAG_LO: prdata_o = r_q.flag[WORD_W-1:0];
                OFF_FLAG_HI: prdata_o = r_q.flag[SRC_NUM-1:WORD_W];
                default:     prdata_o = '0;
            endcase
        end
    end

    assign pready_o = 1'b1;
    assign irq_o    = r_q.gen_en && any_pend;
    assign irq_id_o = irq_o ? top_idx : '0;

    AST_GEN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && paddr_i == OFF_CTRL && !pwdata_i[GEN_BIT]) |=> !irq_o); // R2
    AST_EN_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && paddr_i == OFF_EN_LO && pwdata_i == '0) |=> (pend[WORD_W-1:0] == '0)); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr && paddr_i == OFF_FLAG_LO) |=>
        ((r_q.flag[WORD_W-1:0] & $past(r_q.flag[WORD_W-1:0])) == $past(r_q.flag[WORD_W-1:0]))); // R5
    AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.flag & ~PULSE_MASK) == '0)); // R10
endmodule

// File: tb/apb_irq_ctrl_tb_top.sv
module apb_irq_ctrl_tb_top;
    localparam logic [63:0] PMASK = 64'hFFFF0000_FFFF0000;

    logic        clk = 0, rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = 0;
    logic [31:0] pwdata = 0, prdata, rd;
    logic        pready, irq;
    logic [63:0] src = 0;
    logic [5:0]  irq_id;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    apb_irq_ctrl #(.SYNC_STAGES(2), .PULSE_MASK(PMASK)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
        .pready_o(pready), .src_i(src), .irq_o(irq), .irq_id_o(irq_id)
    );

    // {is_write, addr, data}; for reads data is the expected value
    localparam int NV = 14;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 12'h010, 32'hA5A50F0F},  // R3
        {1'b0, 12'h010, 32'hA5A50F0F},  // R3
        {1'b1, 12'h028, 32'h12345678},  // R3
        {1'b0, 12'h028, 32'h12345678},  // R3
        {1'b1, 12'h014, 32'hFFFFFFFF},  // R3 pending is read-only
        {1'b0, 12'h014, 32'h00000000},  // R3
        {1'b1, 12'h000, 32'hFFFFFFFF},  // R2
        {1'b0, 12'h000, 32'h80000000},  // R2 only bit 31 kept
        {1'b1, 12'h040, 32'h00010203},  // R7
        {1'b0, 12'h040, 32'h00010203},  // R7
        {1'b1, 12'h07C, 32'h3C3D3E3F},  // R7
        {1'b0, 12'h07C, 32'h3C3D3E3F},  // R7
        {1'b1, 12'h080, 32'hDEADBEEF},  // R9
        {1'b0, 12'h080, 32'h00000000}   // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_o", {31'd0, irq}, 0);
        chk("R1 irq_id", {26'd0, irq_id}, 0);
        apb_rd(12'h000, rd); chk("R1 ctrl", rd, 0);
        apb_rd(12'h028, rd); chk("R1 en_hi", rd, 0);
        apb_rd(12'h044, rd); chk("R1 table", rd, 0);
        chk("R9 pready", {31'd0, pready}, 1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) apb_wr(VEC[i][43:32], VEC[i][31:0]);
            else begin
                apb_rd(VEC[i][43:32], rd);
                chk($sformatf("R2/R3/R7/R9 vec%0d", i), rd, VEC[i][31:0]);
            end
        end
        apb_rd(12'h004, rd); chk("R9 unmapped 0x04", rd, 0);
        apb_rd(12'h010, rd); chk("R9 en after stray write", rd, 32'hA5A50F0F);

        apb_wr(12'h010, 32'hFFFFFFFF);
        apb_wr(12'h028, 32'hFFFFFFFF);
        apb_wr(12'h000, 32'h80000000);

        // R4 level latency: two edges
        @(negedge clk); src[5] = 1;
        @(negedge clk); chk("R4 after 1 edge", {31'd0, irq}, 0);
        @(negedge clk); chk("R4 after 2 edges", {31'd0, irq}, 1);
        chk("R8 id 5", {26'd0, irq_id}, 5);
        apb_rd(12'h014, rd); chk("R3 pend_lo", rd, 32'h20);
        src[40] = 1; idle(3);
        chk("R8 id 40", {26'd0, irq_id}, 40);
        apb_rd(12'h02C, rd); chk("R3 pend_hi", rd, 32'h100);
        src[40] = 0; idle(3);
        chk("R8 id back 5", {26'd0, irq_id}, 5);

        // R2 global gate
        apb_wr(12'h000, 32'h0);
        chk("R2 irq gated", {31'd0, irq}, 0);
        chk("R2 id gated", {26'd0, irq_id}, 0);
        apb_rd(12'h014, rd); chk("R2 pend visible", rd, 32'h20);
        apb_wr(12'h000, 32'h80000000);
        chk("R2 irq on", {31'd0, irq}, 1);

        // R3 disable gating
        apb_wr(12'h010, 32'h0);
        apb_rd(12'h014, rd); chk("R3 disabled pend", rd, 0);
        chk("R3 disabled irq", {31'd0, irq}, 0);
        src[5] = 0;
        apb_wr(12'h010, 32'hFFFFFFFF);
        idle(3);
        chk("R4 level drops", {31'd0, irq}, 0);

        // R5 pulse capture
        @(negedge clk); src[20] = 1;
        @(negedge clk); src[20] = 0;
        idle(5);
        apb_rd(12'h008, rd); chk("R5 flag_lo", rd, 32'h0010_0000);
        apb_rd(12'h014, rd); chk("R5 pend from flag", rd, 32'h0010_0000);
        chk("R8 id 20", {26'd0, irq_id}, 20);
        @(negedge clk); src[50] = 1;
        @(negedge clk); src[50] = 0;
        src[3] = 1;
        idle(5);
        apb_rd(12'h020, rd); chk("R5 flag_hi", rd, 32'h0004_0000);
        chk("R8 id 50", {26'd0, irq_id}, 50);
        apb_rd(12'h008, rd); chk("R10 level flag 0", rd, 32'h0010_0000);

        // R6 clearing
        apb_wr(12'h020, 32'h0);
        apb_rd(12'h020, rd); chk("R6 flag_hi cleared", rd, 0);
        chk("R8 id 20 again", {26'd0, irq_id}, 20);
        apb_wr(12'h008, 32'hFFFFFFFF);
        apb_rd(12'h008, rd); chk("R6 write 1 no set", rd, 32'h0010_0000);
        apb_wr(12'h008, ~32'h0010_0000);
        apb_rd(12'h008, rd); chk("R6 flag_lo cleared", rd, 0);
        chk("R8 id 3", {26'd0, irq_id}, 3);

        // R6 held-high pulse input sets once
        src[17] = 1; idle(5);
        apb_rd(12'h008, rd); chk("R5 held flag", rd, 32'h0002_0000);
        apb_wr(12'h008, 32'h0);
        idle(4);
        apb_rd(12'h008, rd); chk("R6 no re-set while high", rd, 0);
        src = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule